// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps wall time as a 32-bit count of seconds. A prescaler divides its input clock, nominally 32.768 kHz, down to a one-second tick. Software programs the tick period through a divider field and can correct the long-term rate with a signed trim value. Each tick advances the seconds counter, and a 32-bit alarm value is compared against the counter on every tick.

A four-bit status/control word holds two event flags and their two interrupt enables. The flags record a tick and an alarm match and are cleared by writing ones. Two interrupt outputs present each flag gated by its enable. Registers are reached through a simple single-cycle read/write port. A parameter picks one of two address layouts.

Top module: `rtc_core`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: With LAYOUT=0 the alarm sits at byte offset 0x00, the counter at 0x04, trim/divider at 0x08 and status at 0x10. Any other offset reads zero and ignores writes.
- R3: With LAYOUT=1 the counter sits at 0x0, the alarm at 0x4, status at 0x8 and trim/divider at 0xC. Offset 0x10 reads zero.
- R4: The divider sits in bits 15:0 of trim/divider. With trim zero, ticks come every divider+1 clock cycles. A write to trim/divider restarts the prescaler, and the first tick follows that write edge by divider+1 cycles.
- R5: A divider field of zero gives a tick period of 32768 cycles, and the field still reads back as zero.
- R6: Trim is a signed 8-bit value in bits 23:16. It is added to the period of every TRIM_INTERVAL-th tick, and that interval count also restarts on a trim/divider write. A sum below one is clamped to one cycle.
- R7: Software can write the counter directly. Each tick adds one, wrapping from 0xFFFFFFFF to 0. A counter write on a tick cycle wins over the increment.
- R8: Status bit 1 sets on every tick. Status bit 0 sets on the tick that makes the counter equal to the alarm, whether or not the alarm enable is set.
- R9: Status bits 1 and 0 clear when a one is written to them, and writing zero leaves them unchanged. Bits 3 (tick enable) and 2 (alarm enable) are plain read/write. A flag that sets in the same cycle as its clear stays set.
- R10: irq_tick is status bit 1 AND bit 3. irq_alarm is status bit 0 AND bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, same cycle |
| irq_tick | output | 1 | One-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The counter is read on the cycle before and the cycle after each expected tick edge. This separates a correct period from one that is off by one, both for plain divider values and for divider zero. Positive and negative trim values are applied against a short trim interval, so the one lengthened or shortened period is told apart from the plain periods around it. Status writes are timed to land on the same edge as a tick and as a counter update, which exposes a wrong priority between set and clear. Writing zeros, clearing with the enables off and matching with the alarm enable off each show whether flags, enables and outputs are kept separate.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_ALARM,
    RSEL_COUNT,
    RSEL_TRIM,
    RSEL_STAT
  } rsel_e;

  localparam int ST_AL_FLAG = 0;
  localparam int ST_HZ_FLAG = 1;
  localparam int ST_AL_EN   = 2;
  localparam int ST_HZ_EN   = 3;
  localparam int ST_W       = 4;

  localparam int LAYOUT_A = 0;
  localparam int LAYOUT_B = 1;
endpackage

// File: rtl/rtc_addr_map.sv
module rtc_addr_map
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LAYOUT = LAYOUT_A
) (
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             sel
);
  generate
    if (LAYOUT == LAYOUT_B) begin : g_layout_b
      always_comb begin
        case (addr)
          ADDR_W'(8'h00): sel = RSEL_COUNT;
          ADDR_W'(8'h04): sel = RSEL_ALARM;
          ADDR_W'(8'h08): sel = RSEL_STAT;
          ADDR_W'(8'h0C): sel = RSEL_TRIM;
          default:        sel = RSEL_NONE;
        endcase
      end
    end else begin : g_layout_a
      always_comb begin
        case (addr)
          ADDR_W'(8'h00): sel = RSEL_ALARM;
          ADDR_W'(8'h04): sel = RSEL_COUNT;
          ADDR_W'(8'h08): sel = RSEL_TRIM;
          ADDR_W'(8'h10): sel = RSEL_STAT;
          default:        sel = RSEL_NONE;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W         = 16,
  parameter int TRIM_W        = 8,
  parameter int TRIM_INTERVAL = 1024,
  parameter int DEFAULT_DIV   = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DIV_W-1:0]  div_val,
  input  logic [TRIM_W-1:0] trim_val,
  output logic              tick
);
  localparam int CNT_W  = DIV_W + 2;
  localparam int SLOT_W = (TRIM_INTERVAL > 2) ? $clog2(TRIM_INTERVAL) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(TRIM_INTERVAL - 1);

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [SLOT_W-1:0]       slot_q, slot_d;
  logic [DIV_W-1:0]        div_eff;
  logic signed [CNT_W:0]   lim_s;
  logic [CNT_W-1:0]        lim;
  logic                    trim_slot;
  logic                    reached;

  // period limit: divider (zero means default) plus trim on the trim slot
  always_comb begin
    div_eff   = (div_val == '0) ? DIV_W'(DEFAULT_DIV) : div_val;
    trim_slot = (slot_q == SLOT_LAST);
    lim_s     = $signed({3'b000, div_eff});
    if (trim_slot) begin
      lim_s = lim_s + $signed({{(CNT_W + 1 - TRIM_W){trim_val[TRIM_W-1]}}, trim_val});
    end
    lim     = lim_s[CNT_W] ? '0 : lim_s[CNT_W-1:0];
    reached = (cnt_q >= lim);
    tick    = reached & ~restart;
  end

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (restart) begin
      cnt_d  = '0;
      slot_d = '0;
    end else if (reached) begin
      cnt_d  = '0;
      slot_d = trim_slot ? '0 : slot_q + 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_wr,
  input  logic              alm_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] seconds,
  output logic [DATA_W-1:0] alarm,
  output logic              match
);
  logic [DATA_W-1:0] sec_q, sec_d, sec_inc;
  logic [DATA_W-1:0] alm_q, alm_d;
  logic              sec_en, alm_en;

  always_comb begin
    sec_inc = sec_q + 1'b1;
    sec_en  = cnt_wr | tick;
    sec_d   = cnt_wr ? wdata : sec_inc;
    alm_en  = alm_wr;
    alm_d   = wdata;
    match   = tick & ~cnt_wr & (sec_inc == alm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      alm_q <= '0;
    end else begin
      if (sec_en) sec_q <= sec_d;
      if (alm_en) alm_q <= alm_d;
    end
  end

  assign seconds = sec_q;
  assign alarm   = alm_q;
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [ST_W-1:0] wdata,
  input  logic            hz_set,
  input  logic            al_set,
  output logic            hz_en,
  output logic            al_en,
  output logic            hz_flag,
  output logic            al_flag
);
  logic hz_en_q, al_en_q, hz_flag_q, al_flag_q;
  logic hz_en_d, al_en_d, hz_flag_d, al_flag_d;

  always_comb begin
    hz_en_d   = wr ? wdata[ST_HZ_EN] : hz_en_q;
    al_en_d   = wr ? wdata[ST_AL_EN] : al_en_q;
    // clear by writing one; a same-cycle set wins
    hz_flag_d = (hz_flag_q & ~(wr & wdata[ST_HZ_FLAG])) | hz_set;
    al_flag_d = (al_flag_q & ~(wr & wdata[ST_AL_FLAG])) | al_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_en_q   <= 1'b0;
      al_en_q   <= 1'b0;
      hz_flag_q <= 1'b0;
      al_flag_q <= 1'b0;
    end else begin
      hz_en_q   <= hz_en_d;
      al_en_q   <= al_en_d;
      hz_flag_q <= hz_flag_d;
      al_flag_q <= al_flag_d;
    end
  end

  assign hz_en   = hz_en_q;
  assign al_en   = al_en_q;
  assign hz_flag = hz_flag_q;
  assign al_flag = al_flag_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32,
  parameter int DIV_W         = 16,
  parameter int TRIM_W        = 8,
  parameter int TRIM_INTERVAL = 1024,
  parameter int DEFAULT_DIV   = 32767,
  parameter int LAYOUT        = LAYOUT_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_tick,
  output logic              irq_alarm
);
  localparam int TT_W = DIV_W + TRIM_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  rsel_e             rsel;
  logic              wr_any, cnt_wr, alm_wr, tt_wr, st_wr;
  logic [TT_W-1:0]   tt_q, tt_d;
  logic              tick;
  logic [DATA_W-1:0] seconds, alarm;
  logic              al_match;
  logic              hz_en, al_en, hz_flag, al_flag;
  logic [ST_W-1:0]   st_wdata;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtc_addr_map #(.ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_map (
    .addr (bus_addr),
    .sel  (rsel)
  );

  always_comb begin
    wr_any   = bus_sel & bus_wr;
    cnt_wr   = wr_any & (rsel == RSEL_COUNT);
    alm_wr   = wr_any & (rsel == RSEL_ALARM);
    tt_wr    = wr_any & (rsel == RSEL_TRIM);
    st_wr    = wr_any & (rsel == RSEL_STAT);
    st_wdata = bus_wdata[ST_W-1:0];
    tt_d     = bus_wdata[TT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  tt_q <= '0;
    else if (tt_wr)  tt_q <= tt_d;
  end

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W),
    .TRIM_INTERVAL(TRIM_INTERVAL), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .restart  (tt_wr),
    .div_val  (tt_q[DIV_W-1:0]),
    .trim_val (tt_q[TT_W-1:DIV_W]),
    .tick     (tick)
  );

  rtc_seconds #(.DATA_W(DATA_W)) u_sec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tick),
    .cnt_wr  (cnt_wr),
    .alm_wr  (alm_wr),
    .wdata   (bus_wdata),
    .seconds (seconds),
    .alarm   (alarm),
    .match   (al_match)
  );

  rtc_status u_st (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (st_wr),
    .wdata   (st_wdata),
    .hz_set  (tick),
    .al_set  (al_match),
    .hz_en   (hz_en),
    .al_en   (al_en),
    .hz_flag (hz_flag),
    .al_flag (al_flag)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rsel)
        RSEL_ALARM: bus_rdata = alarm;
        RSEL_COUNT: bus_rdata = seconds;
        RSEL_TRIM:  bus_rdata = {{(DATA_W-TT_W){1'b0}}, tt_q};
        RSEL_STAT:  bus_rdata = {{(DATA_W-ST_W){1'b0}}, hz_en, al_en, hz_flag, al_flag};
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_tick  = hz_flag & hz_en;
  assign irq_alarm = al_flag & al_en;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_wr,
  input logic              st_wr,
  input logic [3:0]        st_wdata,
  input logic [DATA_W-1:0] seconds,
  input logic              al_match,
  input logic              hz_flag,
  input logic              al_flag
);
  assert_tick_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hz_flag);

  assert_match_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    al_match |=> al_flag);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (seconds == $past(seconds) + 1'b1));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(seconds));

  assert_clear_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_wdata[1] && !tick) |=> !hz_flag);

  assert_keep_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !st_wdata[0] && al_flag) |=> al_flag);
endmodule

bind rtc_core rtc_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .st_wr    (st_wr),
  .st_wdata (st_wdata),
  .seconds  (seconds),
  .al_match (al_match),
  .hz_flag  (hz_flag),
  .al_flag  (al_flag)
);

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
  localparam logic [4:0] A_ALM = 5'h00, A_CNT = 5'h04, A_TRM = 5'h08, A_ST = 5'h10;
  localparam logic [4:0] B_CNT = 5'h00, B_ALM = 5'h04, B_ST = 5'h08, B_TRM = 5'h0C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_a, sel_b, wr, dsel, mon_go;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata_a, rdata_b, rd_mux;
  logic        irq_tick, irq_alarm, irq_tick_b, irq_alarm_b;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  rtc_core #(.LAYOUT(0), .TRIM_INTERVAL(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  rtc_core #(.LAYOUT(1), .TRIM_INTERVAL(4)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_tick(irq_tick_b), .irq_alarm(irq_alarm_b)
  );

  assign rd_mux = dsel ? rdata_b : rdata_a;

  // monitor: pops one expected item per marked cycle, samples mid-cycle
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    if (mon_go && sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {30'b0, irq_alarm, irq_tick} : rd_mux;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    sel_a = 0; sel_b = 0; wr = 0; mon_go = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic op_wr(input bit b, input logic [4:0] a, input logic [31:0] d);
    sel_a = ~b; sel_b = b; wr = 1; addr = a; wdata = d;
    step();
  endtask

  task automatic op_rd(input bit b, input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    sel_a = ~b; sel_b = b; wr = 0; addr = a; dsel = b; mon_go = 1;
    step();
  endtask

  task automatic op_irq(input logic [1:0] e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {30'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel_a = 0; sel_b = 0; wr = 0; dsel = 0; mon_go = 0;
    addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);

    // R3: second layout offsets
    op_wr(1, B_CNT, 32'hAAAA_0001);
    op_wr(1, B_ALM, 32'h5);
    op_wr(1, B_ST, 32'hC);
    op_wr(1, B_TRM, 32'h9);
    op_rd(1, B_CNT, 32'hAAAA_0001, "R3 counter at 0x0");
    op_rd(1, B_ALM, 32'h5, "R3 alarm at 0x4");
    op_rd(1, B_ST, 32'hC, "R3 status at 0x8");
    op_rd(1, B_TRM, 32'h9, "R3 trim/divider at 0xC");
    op_rd(1, 5'h10, 32'h0, "R3 offset 0x10 unmapped");

    // R1: reset state of first instance
    op_rd(0, A_ALM, 0, "R1 alarm reset");
    op_rd(0, A_CNT, 0, "R1 counter reset");
    op_rd(0, A_TRM, 0, "R1 trim reset");
    op_rd(0, A_ST, 0, "R1 status reset");
    op_irq(2'b00, "R1 irqs low after reset");

    // R2: first layout offsets
    op_rd(0, 5'h0C, 0, "R2 offset 0x0C unmapped");
    op_wr(0, A_ALM, 32'h1234_5678);
    op_rd(0, A_ALM, 32'h1234_5678, "R2 alarm at 0x00");
    op_wr(0, 5'h0C, 32'hFFFF_FFFF);
    op_rd(0, 5'h0C, 0, "R2 unmapped write ignored");

    // R4: divider 9 -> tick every 10 cycles after restart edge E
    op_wr(0, A_CNT, 100);
    op_wr(0, A_TRM, 32'h9);            // edge E
    idle(9);
    op_rd(0, A_CNT, 100, "R4 before first tick");
    op_rd(0, A_CNT, 101, "R4 first tick at E+10");
    op_rd(0, A_ST, 32'h2, "R8 tick flag set");
    op_wr(0, A_ST, 32'h0);              // op13
    op_rd(0, A_ST, 32'h2, "R9 zero write keeps flag");
    op_wr(0, A_ST, 32'hE);              // op15: enables on, clear tick flag
    op_rd(0, A_ST, 32'hC, "R9 clear by one, enables kept");
    op_irq(2'b00, "R10 no irq after clear");
    idle(3);
    op_irq(2'b01, "R10 tick irq after E+20");
    op_wr(0, A_ST, 32'h4);              // op22: tick enable off
    op_irq(2'b00, "R10 tick irq gated by enable");
    op_rd(0, A_ST, 32'h6, "R9 enables plain rw");
    idle(5);
    op_wr(0, A_ST, 32'h2);              // op30: clear on tick edge E+30
    op_rd(0, A_ST, 32'h2, "R9 set wins over clear");
    op_wr(0, A_ST, 32'h2);
    op_rd(0, A_ST, 32'h0, "R9 clear after collision");

    // R6 positive trim +3 with interval 4; R8 alarm
    op_wr(0, A_CNT, 50);
    op_wr(0, A_ALM, 53);
    op_wr(0, A_ST, 32'h4);
    op_wr(0, A_TRM, 32'h0003_0009);     // edge E2
    idle(29);
    op_rd(0, A_ST, 32'h6, "R8 before alarm tick");
    op_rd(0, A_ST, 32'h7, "R8 alarm flag on match");
    op_irq(2'b10, "R10 alarm irq");
    idle(10);
    op_rd(0, A_CNT, 53, "R6 lengthened fourth period");
    op_rd(0, A_CNT, 54, "R6 fourth tick at E2+43");
    op_wr(0, A_ST, 32'h3);              // op45
    op_wr(0, A_ALM, 56);                // op46
    idle(16);
    op_rd(0, A_ST, 32'h2, "R8 before match with enable off");
    op_rd(0, A_ST, 32'h3, "R8 alarm pending without enable");
    op_irq(2'b00, "R10 alarm irq gated by enable");

    // R6 negative trim -4
    op_wr(0, A_CNT, 200);
    op_wr(0, A_TRM, 32'h00FC_0009);     // edge E3
    idle(35);
    op_rd(0, A_CNT, 203, "R6 shortened fourth period");
    op_rd(0, A_CNT, 204, "R6 fourth tick at E3+36");

    // R5: divider zero
    op_wr(0, A_CNT, 0);
    op_wr(0, A_TRM, 32'h0);             // edge E4
    idle(32767);
    op_rd(0, A_CNT, 0, "R5 before 32768 cycles");
    op_rd(0, A_CNT, 1, "R5 tick at E4+32768");
    op_rd(0, A_TRM, 0, "R5 zero field reads zero");

    // R7: wrap and write-over-tick
    op_wr(0, A_CNT, 32'hFFFF_FFFF);
    op_wr(0, A_TRM, 32'h9);             // edge E5
    idle(9);
    op_rd(0, A_CNT, 32'hFFFF_FFFF, "R7 written value");
    op_rd(0, A_CNT, 32'h0, "R7 wrap to zero");
    idle(8);
    op_wr(0, A_CNT, 32'h77);            // op20, same edge as tick
    op_rd(0, A_CNT, 32'h77, "R7 write wins over tick");
    op_rd(0, A_CNT, 32'h77, "R7 holds between ticks");

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule